// File: doc/BRIEF.md
# I/Q Sample to Slave-FIFO Streaming Bridge

This block sits between a dual-channel converter front end and the synchronous slave-FIFO port of a USB controller. It runs on one clock. The same clock samples the converter and times the FIFO strobes. Each converted I/Q pair arrives with a valid pulse. The pair is parked in a small skid buffer and then written to the controller as two 16-bit words, I first and Q second. Those writes go to the device-to-host bulk endpoint.

When no acquired data is pending, the bridge switches direction. It selects the host-to-device endpoint and reads words from it, while the controller drives the shared bus. Before the bridge drives the bus again, it inserts one idle turnaround cycle. The bridge obeys the controller's full flag and empty flag. Packets are committed by the controller itself when they fill, so the bridge has no packet-end output.

Top module: `sfifo_stream_bridge`

## Requirements
- R1: Every written word holds the 10-bit sample in bits 9..0, zeros in bits 14..10, and a channel tag in bit 15 (0 = I, 1 = Q).
- R2: Pairs are written in arrival order, the I word directly before the Q word of the same pair, and `ep_sel_o` is 2'b00 in every cycle where `fifo_wr_o` is high.
- R3: `fifo_wr_o` is never high while `out_full_i` is high. Pairs that arrive meanwhile are kept in an 8-pair skid buffer and are written intact once the flag clears.
- R4: A pair that arrives while the skid buffer holds 8 pairs and is not draining is dropped, and `overflow_o` is set. `overflow_o` stays set until reset. The 8 stored pairs are still written.
- R5: In a read, `ep_sel_o` is 2'b10, and `fifo_rd_o` and `fifo_oe_o` are high together, only while `in_empty_i` is low. The word on the bus at that edge appears on `host_data_o` with `host_valid_o` high one cycle later.
- R6: Reads happen only while the skid buffer is empty. After a cycle with `fifo_rd_o` high, the next cycle never has `fifo_wr_o` high.
- R7: While `rst_ni` is low, all strobes are low, the bus is released, `ep_sel_o` is 2'b00 and `host_valid_o` is low. After reset the skid buffer is empty and `overflow_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared sample and interface clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | A converted I/Q pair is present |
| smp_i_i | input | 10 | I channel sample |
| smp_q_i | input | 10 | Q channel sample |
| out_full_i | input | 1 | Device-to-host endpoint is full |
| in_empty_i | input | 1 | Host-to-device endpoint is empty |
| ep_sel_o | output | 2 | Endpoint select code |
| fifo_wr_o | output | 1 | Write strobe |
| fifo_rd_o | output | 1 | Read strobe |
| fifo_oe_o | output | 1 | Controller output enable |
| bus_io | inout | 16 | Shared data bus |
| host_data_o | output | 16 | Last word read from the host |
| host_valid_o | output | 1 | `host_data_o` updated this cycle |
| overflow_o | output | 1 | Sticky skid-buffer overflow |

## Verification
The assertions assume two things about the controller. Its flags are stable over the cycle in which the bridge decides. It drives the bus only while `fifo_oe_o` is high. The bench models both: it changes `out_full_i` only on falling edges, and it derives `in_empty_i` from the count of host words it still has queued. The bench also assumes valid pulses arrive at least two cycles apart, so that draining can keep pace with arrival. The stimulus keeps to that spacing, and it exceeds the buffer only in the overflow scenario, where `out_full_i` is held high on purpose.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  typedef enum logic [1:0] {DIR_WR, DIR_RD, DIR_TURN} dir_e;

  localparam logic [1:0] EP_TO_HOST   = 2'b00;
  localparam logic [1:0] EP_FROM_HOST = 2'b10;

  function automatic logic [15:0] fmt_word(input logic tag, input logic [9:0] smp);
    return {tag, 5'b0, smp};
  endfunction
endpackage

// File: rtl/sfb_skid_fifo.sv
module sfb_skid_fifo #(
  parameter int WIDTH = 20,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             ovf_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;
  logic             full, do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full || do_pop);
  assign data_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (do_push) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
      if (push_i && !do_push) ovf_o <= 1'b1;
    end
  end

  assert_no_pop_empty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  assert_sticky_ovf_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  assert_ovf_only_when_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_o && push_i && !full) |=> !ovf_o);
endmodule

// File: rtl/sfb_dir_arb.sv
module sfb_dir_arb
  import sfb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       skid_empty_i,
  input  logic       out_full_i,
  input  logic       in_empty_i,
  output logic       wr_o,
  output logic       rd_o,
  output logic       oe_o,
  output logic       drive_o,
  output logic [1:0] ep_sel_o
);
  dir_e dir_q, dir_d;

  always_comb begin
    dir_d = dir_q;
    unique case (dir_q)
      DIR_WR:   if (skid_empty_i)  dir_d = DIR_RD;
      DIR_RD:   if (!skid_empty_i) dir_d = DIR_TURN;
      DIR_TURN: dir_d = DIR_WR;
      default:  dir_d = DIR_WR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dir_q <= DIR_WR;
    else         dir_q <= dir_d;
  end

  // acquired data wins: a read needs an empty skid buffer in the same cycle
  assign drive_o  = (dir_q == DIR_WR) && !skid_empty_i;
  assign wr_o     = drive_o && !out_full_i;
  assign rd_o     = (dir_q == DIR_RD) && skid_empty_i && !in_empty_i;
  assign oe_o     = rd_o;
  assign ep_sel_o = (dir_q == DIR_RD) ? EP_FROM_HOST : EP_TO_HOST;

  assert_wr_not_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> !out_full_i);
  assert_wr_ep_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> ep_sel_o == 2'b00);
  assert_rd_ep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> (ep_sel_o == 2'b10 && !in_empty_i && oe_o));
  assert_rd_prio_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> skid_empty_i);
  assert_turn_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> !wr_o);
endmodule

// File: rtl/sfifo_stream_bridge.sv
module sfifo_stream_bridge
  import sfb_pkg::*;
#(
  parameter int SMP_W  = 10,
  parameter int SKID_D = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_i_i,
  input  logic [SMP_W-1:0] smp_q_i,
  input  logic             out_full_i,
  input  logic             in_empty_i,
  output logic [1:0]       ep_sel_o,
  output logic             fifo_wr_o,
  output logic             fifo_rd_o,
  output logic             fifo_oe_o,
  inout  wire  [15:0]      bus_io,
  output logic [15:0]      host_data_o,
  output logic             host_valid_o,
  output logic             overflow_o
);
  localparam int PAIR_W = 2 * SMP_W;

  logic [PAIR_W-1:0] head;
  logic              skid_empty, drive, phase_q, pop;
  logic [15:0]       wr_word;

  assign pop = fifo_wr_o && phase_q;

  sfb_skid_fifo #(.WIDTH(PAIR_W), .DEPTH(SKID_D)) i_skid (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (smp_valid_i),
    .data_i  ({smp_q_i, smp_i_i}),
    .pop_i   (pop),
    .data_o  (head),
    .empty_o (skid_empty),
    .ovf_o   (overflow_o)
  );

  sfb_dir_arb i_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .skid_empty_i (skid_empty),
    .out_full_i   (out_full_i),
    .in_empty_i   (in_empty_i),
    .wr_o         (fifo_wr_o),
    .rd_o         (fifo_rd_o),
    .oe_o         (fifo_oe_o),
    .drive_o      (drive),
    .ep_sel_o     (ep_sel_o)
  );

  always_comb begin
    if (phase_q) wr_word = fmt_word(1'b1, head[PAIR_W-1:SMP_W]);
    else         wr_word = fmt_word(1'b0, head[SMP_W-1:0]);
  end

  assign bus_io = drive ? wr_word : 16'bz;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q      <= 1'b0;
      host_data_o  <= '0;
      host_valid_o <= 1'b0;
    end else begin
      if (fifo_wr_o) phase_q <= !phase_q;
      host_valid_o <= fifo_rd_o;
      if (fifo_rd_o) host_data_o <= bus_io;
    end
  end

  assert_no_drive_on_oe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_oe_o |-> !fifo_wr_o);
  assert_q_follows_i_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_wr_o && !phase_q) |=> (phase_q && !skid_empty));
endmodule

// File: tb/test_sfifo_stream_bridge.sv
module test_sfifo_stream_bridge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [9:0] si = '0, sq = '0;
  logic out_full = 1'b0;
  logic in_empty;
  logic [1:0] ep;
  logic wr, rd, oe, hvalid, ovf;
  logic [15:0] hdata, host_word;
  wire  [15:0] bus;

  int checks = 0, fails = 0;
  int h_idx = 0, h_lim = 0;
  int turn_viol = 0, ep_viol = 0;
  logic prev_rd = 1'b0;
  logic [15:0] cap[$];
  logic [15:0] hcap[$];

  always #5 clk = ~clk;

  function automatic logic [15:0] hw(int k);
    return 16'(32'hA500 ^ (k * 32'h0123));
  endfunction
  function automatic logic [9:0] ei(int k); return 10'((k * 37 + 5) % 1024); endfunction
  function automatic logic [9:0] eq(int k); return 10'((k * 91 + 3) % 1024); endfunction

  assign host_word = hw(h_idx);
  assign in_empty  = (h_idx >= h_lim);
  assign bus = oe ? host_word : 16'bz;

  sfifo_stream_bridge i_sfifo_stream_bridge (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(valid), .smp_i_i(si), .smp_q_i(sq),
    .out_full_i(out_full), .in_empty_i(in_empty), .ep_sel_o(ep), .fifo_wr_o(wr),
    .fifo_rd_o(rd), .fifo_oe_o(oe), .bus_io(bus), .host_data_o(hdata),
    .host_valid_o(hvalid), .overflow_o(ovf));

  // controller model
  always @(posedge clk) begin
    if (wr) begin
      cap.push_back(bus);
      if (prev_rd) turn_viol++;
      if (ep != 2'b00) ep_viol++;
    end
    if (rd) begin
      if (ep != 2'b10 || !oe) ep_viol++;
      h_idx <= h_idx + 1;
    end
    if (hvalid) hcap.push_back(hdata);
    prev_rd <= rd;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    out_full = 1'b0;
    h_lim = h_idx;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push_pair(int k);
    @(negedge clk);
    valid = 1'b1; si = ei(k); sq = eq(k);
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic check_words(int base, int n, string req);
    chk(cap.size() == 2 * n, req, cap.size(), 2 * n);
    for (int i = 0; i < n && 2 * i + 1 < cap.size(); i++) begin
      chk(cap[2*i] == {6'b0, ei(base + i)}, req, cap[2*i], {6'b0, ei(base + i)});
      chk(cap[2*i+1] == {1'b1, 5'b0, eq(base + i)}, req, cap[2*i+1], {1'b1, 5'b0, eq(base + i)});
    end
  endtask

  task automatic t_reset_R7();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!wr && !rd && !oe, "R7 strobes", {wr, rd, oe}, 0);
    chk(ep == 2'b00, "R7 ep", ep, 0);
    chk(!hvalid, "R7 host_valid", hvalid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ovf, "R7 overflow", ovf, 0);
  endtask

  task automatic t_stream_R1_R2();
    do_reset();
    cap.delete();
    for (int k = 0; k < 4; k++) push_pair(k);
    repeat (10) @(negedge clk);
    check_words(0, 4, "R1/R2 stream");
    chk(ep_viol == 0, "R2 ep while writing", ep_viol, 0);
  endtask

  task automatic t_full_hold_R3();
    do_reset();
    cap.delete();
    out_full = 1'b1;
    for (int k = 10; k < 14; k++) push_pair(k);
    repeat (6) @(negedge clk);
    chk(cap.size() == 0, "R3 no write while full", cap.size(), 0);
    out_full = 1'b0;
    repeat (12) @(negedge clk);
    check_words(10, 4, "R3 held pairs");
  endtask

  task automatic t_overflow_R4();
    do_reset();
    cap.delete();
    out_full = 1'b1;
    for (int k = 20; k < 28; k++) push_pair(k);
    chk(!ovf, "R4 no overflow at 8", ovf, 0);
    push_pair(28);
    @(negedge clk);
    chk(ovf, "R4 overflow set", ovf, 1);
    out_full = 1'b0;
    repeat (20) @(negedge clk);
    check_words(20, 8, "R4 stored pairs");
    chk(ovf, "R4 overflow sticky", ovf, 1);
    do_reset();
    chk(!ovf, "R7 overflow cleared", ovf, 0);
  endtask

  task automatic t_read_R5();
    int start;
    do_reset();
    hcap.delete();
    start = h_idx;
    repeat (3) @(negedge clk);
    chk(!rd && !oe, "R5 no read while empty", {rd, oe}, 0);
    h_lim = h_idx + 5;
    repeat (10) @(negedge clk);
    chk(hcap.size() == 5, "R5 words read", hcap.size(), 5);
    for (int i = 0; i < hcap.size(); i++)
      chk(hcap[i] == hw(start + i), "R5 host data", hcap[i], hw(start + i));
    chk(ep_viol == 0, "R5 ep/oe while reading", ep_viol, 0);
  endtask

  task automatic t_priority_R6();
    int start;
    do_reset();
    hcap.delete();
    cap.delete();
    start = h_idx;
    h_lim = h_idx + 1000;
    repeat (4) @(negedge clk);
    chk(rd, "R6 reading before samples", rd, 1);
    push_pair(40);
    @(negedge clk);
    chk(!rd, "R6 read yields to samples", rd, 0);
    repeat (8) @(negedge clk);
    check_words(40, 1, "R6 write after read");
    chk(turn_viol == 0, "R6 turnaround gap", turn_viol, 0);
    for (int i = 0; i < hcap.size(); i++)
      chk(hcap[i] == hw(start + i), "R6 host data intact", hcap[i], hw(start + i));
    h_lim = h_idx;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    t_reset_R7();
    t_stream_R1_R2();
    t_full_hold_R3();
    t_overflow_R4();
    t_read_R5();
    t_priority_R6();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule